// File: doc/BRIEF.md
# Chip-Select-Gated I2C Configuration Register Slave

This block is a two-wire serial slave that sits in front of a small configuration register file for a clock-generation subsystem. The serial clock and data lines are brought into the system clock domain through synchronizers, and the start and stop conditions are recovered from them. A protocol engine then walks the address byte, a register pointer byte and the data bytes, acknowledging by pulling the data line low. It returns read data the same way, pulling low for zero bits and releasing for one bits.

The block is not selected by matching its bus address. An active-low select input gates it instead: while the select is high the slave is deaf and silent. While it is low, any nonzero 7-bit address is accepted. The all-zero general-call address is refused. The register contents are presented as parallel outputs: a low-power (hibernate) control, two output-enable/drive-strength pairs, and the fractional feedback divider, integer feedback divider and two output divider values of a PLL. The intended bus rate is 400 kHz, oversampled by a much faster system clock.

Top module: `csi2c_slave`

## Requirements
- R1: After reset, register 0x10 reads 0x00, register 0x11 reads 0xFF (both drive fields 111, both enables set), and registers 0x13 to 0x17 read 0x00.
- R2: While `cs_n` is high, the slave never pulls SDA low, acknowledges nothing and changes no register.
- R3: With `cs_n` low, an address byte whose upper seven bits are nonzero is acknowledged in either direction. An all-zero address is not acknowledged, and the bytes that follow it have no effect until a new START.
- R4: In a write, the first byte after the address loads the register pointer. Each further byte is stored at the pointer, and the pointer then increments by one.
- R5: In a read, the slave sends the byte at the pointer, MSB first. After each byte the master acknowledges, the pointer increments and the next byte is sent. A master NACK releases SDA and ends the transfer.
- R6: Register 0x11 bit 0 is output-1 enable, bits 3:1 are output-1 drive strength, bit 4 is output-2 enable, and bits 7:5 are output-2 drive strength.
- R7: While bit 5 of register 0x10 is set, both enable outputs are low. The stored enable bits are kept and take effect again when bit 5 clears.
- R8: Register 0x13 is fraction bits 7:0 and register 0x14 is fraction bits 15:8. Register 0x15 holds fraction bit 16 in bit 0 and the 7-bit integer divider in bits 7:1. Register 0x16 is output divider 1 and register 0x17 is output divider 2.
- R9: A write to an address outside 0x10, 0x11 and 0x13 to 0x17 is discarded, but the pointer still increments. A read from such an address returns 0x00.
- R10: A STOP at any point, or a START after two or more SCL rises of a byte, abandons the transfer. The partial byte is not stored, and later bytes are ignored until the next START.
- R11: SDA is only ever pulled low or released (`sda_oe`), and `sda_oe` changes only while SCL is low.
- R12: A repeated START at a byte boundary begins a new address phase with the pointer kept, so a pointer write followed by a read returns data from that pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low select; high makes the slave ignore the bus |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| hib | output | 1 | Hibernate control (register 0x10 bit 5) |
| o1_en | output | 1 | Output-1 enable, forced low in hibernate |
| o1_drv | output | 3 | Output-1 drive strength |
| o2_en | output | 1 | Output-2 enable, forced low in hibernate |
| o2_drv | output | 3 | Output-2 drive strength |
| pll_frac | output | 17 | PLL fractional divider value |
| pll_int | output | 7 | PLL integer divider value |
| div1 | output | 8 | Output-1 divider value |
| div2 | output | 8 | Output-2 divider value |

## Verification
The assertions assume SCL stays low for several system clocks after each falling edge. Under that assumption, a change of `sda_oe` seen one cycle after a detected fall is still inside the low phase. The assertions also assume the master changes SDA only while SCL is low, except when it signals START and STOP. The stimulus holds every SCL phase for eight system clocks and moves SDA only a full phase after SCL falls. It asserts and releases `cs_n` only between transfers, and then only while the bus is idle.

// File: rtl/csi2c_pkg.sv
package csi2c_pkg;

    localparam int BYTE_W   = 8;
    localparam int CNT_W    = 4;
    localparam int PLL_REGS = 5;
    localparam int HIB_BIT  = 5;

    localparam logic [7:0] REG_CTL   = 8'h10;
    localparam logic [7:0] REG_DRV   = 8'h11;
    localparam logic [7:0] REG_PLL0  = 8'h13;
    localparam logic [7:0] DRV_RESET = 8'hFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK,
        ST_RX,
        ST_TX,
        ST_MACK
    } bus_st_t;

    // Output drive control register, fields in bit order 7..0.
    typedef struct packed {
        logic [2:0] o2_drv;
        logic       o2_en;
        logic [2:0] o1_drv;
        logic       o1_en;
    } drv_t;

    function automatic logic is_pll(input logic [7:0] a);
        return (a >= REG_PLL0) && (a < REG_PLL0 + 8'(PLL_REGS));
    endfunction

endpackage

// File: rtl/csi2c_sync.sv
module csi2c_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe, sda_pipe;
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_lvl   = scl_pipe[STAGES-1];
    assign sda_lvl   = sda_pipe[STAGES-1];
    assign scl_rise  = scl_lvl & ~scl_q;
    assign scl_fall  = ~scl_lvl & scl_q;
    assign start_det = scl_lvl & scl_q & sda_q & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_q & ~sda_q & sda_lvl;

endmodule

// File: rtl/csi2c_engine.sv
module csi2c_engine
    import csi2c_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic       scl_lvl,
    input  logic       sda_lvl,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic [7:0] rd_data,
    output logic [7:0] ptr,
    output logic       wr_en,
    output logic [7:0] wr_addr,
    output logic [7:0] wr_data,
    output logic       sda_oe
);
    bus_st_t           st;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] sh;
    logic              rw, need_ptr, mack;

    logic at_boundary;
    assign at_boundary = (st == ST_IDLE) ||
                         ((st == ST_ADDR || st == ST_RX) && cnt <= CNT_W'(1));

    always_ff @(posedge clk) begin
        wr_en <= 1'b0;
        if (rst) begin
            st       <= ST_IDLE;
            cnt      <= '0;
            sh       <= '0;
            sda_oe   <= 1'b0;
            ptr      <= '0;
            rw       <= 1'b0;
            need_ptr <= 1'b0;
            mack     <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else if (cs_n || stop_det) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            sda_oe <= 1'b0;
        end else if (start_det) begin
            st     <= at_boundary ? ST_ADDR : ST_IDLE;
            cnt    <= '0;
            sda_oe <= 1'b0;
        end else begin
            if (scl_rise && st != ST_IDLE)
                cnt <= cnt + CNT_W'(1);
            unique case (st)
                ST_ADDR, ST_RX: begin
                    if (scl_rise) begin
                        sh <= {sh[BYTE_W-2:0], sda_lvl};
                    end else if (scl_fall && cnt == CNT_W'(BYTE_W)) begin
                        cnt <= '0;
                        if (st == ST_ADDR) begin
                            if (sh[7:1] != 7'd0) begin
                                sda_oe   <= 1'b1;
                                st       <= ST_ACK;
                                rw       <= sh[0];
                                need_ptr <= ~sh[0];
                            end else begin
                                st <= ST_IDLE;
                            end
                        end else begin
                            if (need_ptr) begin
                                ptr      <= sh;
                                need_ptr <= 1'b0;
                            end else begin
                                wr_en   <= 1'b1;
                                wr_addr <= ptr;
                                wr_data <= sh;
                                ptr     <= ptr + 8'd1;
                            end
                            sda_oe <= 1'b1;
                            st     <= ST_ACK;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        cnt <= '0;
                        if (rw) begin
                            sh     <= rd_data;
                            sda_oe <= ~rd_data[7];
                            st     <= ST_TX;
                        end else begin
                            sda_oe <= 1'b0;
                            st     <= ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (cnt == CNT_W'(BYTE_W)) begin
                            sda_oe <= 1'b0;
                            cnt    <= '0;
                            mack   <= 1'b0;
                            st     <= ST_MACK;
                        end else begin
                            sh     <= {sh[BYTE_W-2:0], 1'b0};
                            sda_oe <= ~sh[BYTE_W-2];
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        mack <= ~sda_lvl;
                        if (!sda_lvl)
                            ptr <= ptr + 8'd1;
                    end else if (scl_fall) begin
                        cnt <= '0;
                        if (mack) begin
                            sh     <= rd_data;
                            sda_oe <= ~rd_data[7];
                            st     <= ST_TX;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R2: a held-high select keeps the data line released
    a_r2_cs_quiet: assert property (@(posedge clk) disable iff (rst)
        (cs_n && $past(cs_n)) |-> !sda_oe);

    // R3: the acknowledge phase is only reached for a nonzero address
    a_r3_no_general_call: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ACK && $past(st) == ST_ADDR) |-> ($past(sh[7:1]) != 7'd0));

    // R4: every stored byte advances the pointer past its own address
    a_r4_ptr_advance: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (ptr == wr_addr + 8'd1));

    // R11: the line driver only moves while SCL is low
    a_r11_oe_scl_low: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !$past(cs_n) && sda_oe != $past(sda_oe)) |-> !scl_lvl);

endmodule

// File: rtl/csi2c_regs.sv
module csi2c_regs
    import csi2c_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [7:0]              wr_addr,
    input  logic [7:0]              wr_data,
    input  logic [7:0]              rd_addr,
    output logic [7:0]              rd_data,
    output logic [7:0]              ctl_q,
    output drv_t                    drv_q,
    output logic [PLL_REGS*8-1:0]   pll_flat
);
    logic [7:0] pll_r [PLL_REGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            drv_q <= drv_t'(DRV_RESET);
            for (int i = 0; i < PLL_REGS; i++)
                pll_r[i] <= '0;
        end else if (wr_en) begin
            if (wr_addr == REG_CTL)
                ctl_q <= wr_data;
            if (wr_addr == REG_DRV)
                drv_q <= drv_t'(wr_data);
            for (int i = 0; i < PLL_REGS; i++)
                if (wr_addr == REG_PLL0 + 8'(i))
                    pll_r[i] <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == REG_CTL)
            rd_data = ctl_q;
        else if (rd_addr == REG_DRV)
            rd_data = drv_q;
        else if (is_pll(rd_addr))
            rd_data = pll_r[rd_addr - REG_PLL0];
    end

    for (genvar g = 0; g < PLL_REGS; g++) begin : g_pack
        assign pll_flat[g*8 +: 8] = pll_r[g];
    end

    // R6: a write to the drive register is visible on the next cycle
    a_r6_drv_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == REG_DRV) |=> (drv_q == drv_t'($past(wr_data))));

    // R9: a write outside the map leaves every register alone
    a_r9_unmapped_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr != REG_CTL && wr_addr != REG_DRV && !is_pll(wr_addr))
        |=> ($stable(ctl_q) && $stable(drv_q) && $stable(pll_flat)));

endmodule

// File: rtl/csi2c_slave.sv
module csi2c_slave
    import csi2c_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cs_n,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe,
    output logic        hib,
    output logic        o1_en,
    output logic [2:0]  o1_drv,
    output logic        o2_en,
    output logic [2:0]  o2_drv,
    output logic [16:0] pll_frac,
    output logic [6:0]  pll_int,
    output logic [7:0]  div1,
    output logic [7:0]  div2
);
    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic [7:0] ptr, rd_data, wr_addr, wr_data, ctl_q;
    logic wr_en;
    drv_t drv_q;
    logic [PLL_REGS*8-1:0] pll_flat;

    csi2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
    );

    csi2c_engine u_engine (
        .clk(clk), .rst(rst), .cs_n(cs_n),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .rd_data(rd_data), .ptr(ptr), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sda_oe(sda_oe)
    );

    csi2c_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(ptr), .rd_data(rd_data),
        .ctl_q(ctl_q), .drv_q(drv_q), .pll_flat(pll_flat)
    );

    assign hib      = ctl_q[HIB_BIT];
    assign o1_en    = drv_q.o1_en & ~hib;
    assign o2_en    = drv_q.o2_en & ~hib;
    assign o1_drv   = drv_q.o1_drv;
    assign o2_drv   = drv_q.o2_drv;
    assign pll_frac = {pll_flat[16], pll_flat[15:0]};
    assign pll_int  = pll_flat[23:17];
    assign div1     = pll_flat[31:24];
    assign div2     = pll_flat[39:32];

endmodule

// File: tb/csi2c_slave_test.sv
module csi2c_slave_test;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst = 1'b1, cs_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
    logic sda_line;
    logic sda_oe, hib, o1_en, o2_en;
    logic [2:0] o1_drv, o2_drv;
    logic [16:0] pll_frac;
    logic [6:0] pll_int;
    logic [7:0] div1, div2;

    assign sda_line = sda_m & ~sda_oe;

    csi2c_slave uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .hib(hib), .o1_en(o1_en), .o1_drv(o1_drv),
        .o2_en(o2_en), .o2_drv(o2_drv), .pll_frac(pll_frac),
        .pll_int(pll_int), .div1(div1), .div2(div2)
    );

    localparam int Q = 8;
    localparam logic [6:0] SADDR = 7'h5A;

    int total = 0, bad = 0;
    int hi_moves = 0, cs_drives = 0;
    logic [7:0] exp_q[$];
    logic [7:0] act_q[$];
    bit done = 1'b0;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Monitor: compares each byte read from the bus with the scoreboard.
    initial begin
        forever begin
            wait (act_q.size() != 0);
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R5 unexpected read byte actual=%0h expected=none", act_q[0]);
                void'(act_q.pop_front());
            end else begin
                check("R5 read byte", {24'd0, act_q.pop_front()}, {24'd0, exp_q.pop_front()});
            end
        end
    end

    // R11 / R2 line watch, sampled away from the clock edge.
    initial begin
        logic prev_oe = 1'b0;
        logic prev_cs = 1'b0;
        forever begin
            @(negedge clk);
            if (!rst && !cs_n && sda_oe !== prev_oe && scl_m) hi_moves++;
            if (!rst && cs_n && prev_cs && sda_oe) cs_drives++;
            prev_oe = sda_oe;
            prev_cs = cs_n;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
        end
    end

    task automatic i2c_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic wr_bit(input logic b);
        sda_m = b; tick(Q);
        scl_m = 1'b1; tick(2*Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) wr_bit(b[i]);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        ack = sda_line; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input logic master_ack);
        logic [7:0] v = '0;
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            tick(Q);
            scl_m = 1'b1; tick(Q);
            v = {v[6:0], sda_line}; tick(Q);
            scl_m = 1'b0;
        end
        tick(Q);
        sda_m = ~master_ack; tick(Q);
        scl_m = 1'b1; tick(2*Q);
        scl_m = 1'b0; tick(Q);
        sda_m = 1'b1;
        act_q.push_back(v);
    endtask

    // Full write: address, pointer, data bytes; checks every acknowledge.
    task automatic write_regs(input string req, input logic [7:0] p, input logic [7:0] d[$]);
        logic a;
        i2c_start();
        send_byte({SADDR, 1'b0}, a); check({req, " addr ack"}, a, 0);
        send_byte(p, a);             check({req, " ptr ack"}, a, 0);
        foreach (d[i]) begin
            send_byte(d[i], a);      check({req, " data ack"}, a, 0);
        end
        i2c_stop();
        tick(4);
    endtask

    // Pointer write, repeated start, read n bytes; last byte NACKed.
    task automatic read_regs(input logic [7:0] p, input logic [7:0] e[$]);
        logic a;
        i2c_start();
        send_byte({SADDR, 1'b0}, a); check("R12 addr ack", a, 0);
        send_byte(p, a);             check("R12 ptr ack", a, 0);
        i2c_start();
        send_byte({SADDR, 1'b1}, a); check("R12 read addr ack", a, 0);
        foreach (e[i]) begin
            exp_q.push_back(e[i]);
            recv_byte(i != e.size() - 1);
        end
        tick(2);
        check("R5 released after NACK", sda_oe, 0);
        i2c_stop();
        tick(4);
    endtask

    initial begin
        logic a;
        tick(5);
        rst = 1'b0;
        tick(5);

        // R1 reset state
        check("R1 hib", hib, 0);
        check("R1 enables", {o2_en, o1_en}, 2'b11);
        check("R1 drive", {o2_drv, o1_drv}, 6'o77);
        check("R1 pll", {pll_int, pll_frac}, 0);
        check("R1 dividers", {div2, div1}, 0);
        read_regs(8'h10, '{8'h00, 8'hFF, 8'h00, 8'h00});

        // R4 / R8 sequential write of the PLL block
        write_regs("R4", 8'h13, '{8'h8E, 8'hE3, 8'h8A, 8'h05, 8'h19});
        check("R8 fraction", pll_frac, 17'h0E38E);
        check("R8 integer", pll_int, 7'd69);
        check("R8 div1", div1, 8'h05);
        check("R8 div2", div2, 8'h19);
        write_regs("R8", 8'h15, '{8'h01});
        check("R8 fraction bit16", pll_frac, 17'h1E38E);
        check("R8 integer cleared", pll_int, 7'd0);
        read_regs(8'h13, '{8'h8E, 8'hE3, 8'h01, 8'h05, 8'h19});

        // R6 drive fields
        write_regs("R6", 8'h11, '{8'hA5});
        check("R6 o1_en", o1_en, 1);
        check("R6 o1_drv", o1_drv, 3'b010);
        check("R6 o2_en", o2_en, 0);
        check("R6 o2_drv", o2_drv, 3'b101);

        // R7 hibernate gating
        write_regs("R7", 8'h10, '{8'h20, 8'hFF});
        check("R7 hib set", hib, 1);
        check("R7 enables forced low", {o2_en, o1_en}, 2'b00);
        check("R7 drive kept", {o2_drv, o1_drv}, 6'o77);
        write_regs("R7", 8'h10, '{8'h00});
        check("R7 enables restored", {o2_en, o1_en}, 2'b11);

        // R9 unmapped write skipped, pointer moves on
        write_regs("R9", 8'h12, '{8'h77, 8'h33});
        check("R9 next register written", pll_frac[7:0], 8'h33);
        read_regs(8'h12, '{8'h00, 8'h33});
        read_regs(8'h7F, '{8'h00});

        // R3 general call refused, trailing bytes ignored
        i2c_start();
        send_byte(8'h00, a);   check("R3 general call nack", a, 1);
        send_byte(8'h11, a);   check("R3 after gc ignored", a, 1);
        send_byte(8'h00, a);
        i2c_stop(); tick(4);
        check("R3 drive unchanged", {o2_drv, o1_drv}, 6'o77);
        // R3 another nonzero address acknowledged
        i2c_start();
        send_byte({7'h01, 1'b0}, a); check("R3 addr 0x01 ack", a, 0);
        i2c_stop(); tick(4);

        // R2 select high: deaf and silent
        cs_n = 1'b1; tick(4);
        i2c_start();
        send_byte({SADDR, 1'b0}, a); check("R2 no ack", a, 1);
        send_byte(8'h11, a);
        send_byte(8'h00, a);
        i2c_stop(); tick(4);
        cs_n = 1'b0; tick(4);
        check("R2 drive unchanged", {o2_en, o1_en, o2_drv, o1_drv}, {2'b11, 6'o77});
        check("R2 never drove", cs_drives, 0);

        // R10 STOP mid-byte
        i2c_start();
        send_byte({SADDR, 1'b0}, a);
        send_byte(8'h16, a);
        wr_bit(1'b1); wr_bit(1'b0); wr_bit(1'b1);
        i2c_stop(); tick(4);
        check("R10 stop abort", div1, 8'h05);
        // R10 START mid-byte, then bytes without a new START
        i2c_start();
        send_byte({SADDR, 1'b0}, a);
        send_byte(8'h16, a);
        wr_bit(1'b0); wr_bit(1'b1); wr_bit(1'b0); wr_bit(1'b1);
        i2c_start();
        send_byte(8'h55, a); check("R10 start abort no ack", a, 1);
        send_byte(8'hAA, a);
        i2c_stop(); tick(4);
        check("R10 div1 kept", div1, 8'h05);

        wait (act_q.size() == 0);
        tick(2);
        check("R5 scoreboard drained", exp_q.size(), 0);
        check("R11 no sda_oe change with SCL high", hi_moves, 0);
        done = 1'b1;
        summary();
    end

endmodule